// File: doc/BRIEF.md
# Omega Multistage Switch Network

This block is a self-routing multistage interconnect that connects a power-of-two number of injection ports to the same number of delivery ports. It has as many stages as there are address bits. Each stage holds half as many two-by-two switch elements as there are ports. The stages are joined by a perfect-shuffle permutation, which rotates the port index left by one bit. The element count grows as ports/2 times log2(ports), not as the square of the port count.

Each injected message carries a valid flag, a destination address and a payload. Its source address is the index of the port it entered on. In stage i, counting from zero, a switch compares source address bit i and destination address bit i, where bit 0 is the most significant bit. If the two bits are equal the message goes straight through. If they differ the message crosses over.

Two messages can need the same switch output in the same cycle. In that case the message on the upper switch input keeps the link. The message on the lower input is dropped, and its source is flagged as blocked. A dropped message takes no link in any later stage. Every stage registers its outputs, so a new set of messages can be injected every cycle.

Top module: `omega_net`

## Requirements
- R1: Reset is synchronous and active high. In the first cycle after reset, every `out_valid` bit and every `blocked` bit is 0.
- R2: A message that is not blocked appears on the output port whose index equals its destination address. It appears exactly STAGES clock edges after the edge that samples it. STAGES is 3 by default. The payload is unchanged.
- R3: When `out_valid[k]` is 1, `out_src[k]` gives the index of the input port that injected the message.
- R4: Identity routing, uniform cyclic shifts and bitwise-complement routing with all ports valid are delivered with no `blocked` bit set.
- R5: When both inputs of a switch need the same output, the upper input (even port index after the shuffle) wins. The lower message is not delivered. Its source bit in `blocked` is 1 in the same cycle the other messages of its injection set are delivered. For example, source 2 to destination 7 together with source 6 to destination 4 delivers source 2 and blocks source 6.
- R6: A message dropped in an early stage takes no link in any later stage. For every injection set, the outputs and `blocked` flags match a stage-by-stage conflict model. In that model, each delivered-or-blocked message is counted exactly once.
- R7: An input whose `in_valid` bit is 0 produces no delivery and no `blocked` bit.
- R8: Injection sets that enter on consecutive cycles travel independently. Each set's results appear in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | PORTS | Per-input message present |
| in_dst | input | PORTS x ADDR_W | Per-input destination address |
| in_data | input | PORTS x DATA_W | Per-input payload |
| out_valid | output | PORTS | Per-output message delivered |
| out_src | output | PORTS x ADDR_W | Source index of the delivered message |
| out_data | output | PORTS x DATA_W | Payload of the delivered message |
| blocked | output | PORTS | Per-source flag: message lost to a link conflict |

## Verification
The hardest case to reach is a conflict in the middle or last stage. It must involve a message that survived earlier stages while another message was dropped upstream, because that dropped message must then not cause any further blocking. Directed patterns only reach the documented two-message clash and the all-to-one case. So the bench also drives many pseudo-random sets of destinations and valid bits from a software LFSR. It compares each set against an independent destination-tag model that tracks every message's position stage by stage. A back-to-back test overlaps two sets in the pipeline to show that they do not interfere.

// File: rtl/omega_pkg.sv
package omega_pkg;
    parameter int unsigned ADDR_W = 3;
    parameter int unsigned DATA_W = 16;
    localparam int unsigned PORTS  = 1 << ADDR_W;
    localparam int unsigned STAGES = ADDR_W;
    localparam int unsigned SW_PER_STAGE = PORTS / 2;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [DATA_W-1:0] data;
    } flit_t;

    // index reached through the inter-stage shuffle (rotate left by one)
    function automatic int unsigned shuffle_idx(input int unsigned j);
        return ((j << 1) | (j >> (ADDR_W - 1))) % PORTS;
    endfunction
endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int unsigned BIT = 0
) (
    input  flit_t up_i,
    input  flit_t lo_i,
    output flit_t up_o,
    output flit_t lo_o,
    output logic  lo_lost_o
);
    logic up_cross, lo_cross, clash;

    always_comb begin
        up_cross = up_i.src[BIT] ^ up_i.dst[BIT];
        lo_cross = lo_i.src[BIT] ^ lo_i.dst[BIT];
        // upper leaves on port up_cross, lower on port !lo_cross
        clash    = up_i.vld && lo_i.vld && (up_cross == !lo_cross);
        up_o = '0;
        lo_o = '0;
        if (lo_i.vld && !clash) begin
            if (lo_cross) up_o = lo_i;
            else          lo_o = lo_i;
        end
        if (up_i.vld) begin
            if (up_cross) lo_o = up_i;
            else          up_o = up_i;
        end
        lo_lost_o = clash;
    end
endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int unsigned STAGE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  flit_t             in_f    [PORTS],
    input  logic [PORTS-1:0]  in_blk,
    output flit_t             out_f   [PORTS],
    output logic [PORTS-1:0]  out_blk
);
    localparam int unsigned BIT = ADDR_W - 1 - STAGE;

    flit_t                   shuf [PORTS];
    flit_t                   swo  [PORTS];
    logic [SW_PER_STAGE-1:0] lost;
    logic [PORTS-1:0]        new_blk, shuf_v, swo_v;

    for (genvar j = 0; j < PORTS; j++) begin : g_shuf
        localparam int unsigned D = shuffle_idx(j);
        assign shuf[D] = in_f[j];
    end

    for (genvar s = 0; s < SW_PER_STAGE; s++) begin : g_sw
        omega_switch #(.BIT(BIT)) u_sw (
            .up_i     (shuf[2*s]),
            .lo_i     (shuf[2*s+1]),
            .up_o     (swo[2*s]),
            .lo_o     (swo[2*s+1]),
            .lo_lost_o(lost[s])
        );

        // R5
        upper_wins_chk: assert property (@(posedge clk) disable iff (rst)
            shuf[2*s].vld |-> (shuf[2*s].dst[BIT] ? (swo[2*s+1] == shuf[2*s])
                                                  : (swo[2*s]   == shuf[2*s])));
        // R5
        lost_needs_pair_chk: assert property (@(posedge clk) disable iff (rst)
            lost[s] |-> (shuf[2*s].vld && shuf[2*s+1].vld));
    end

    always_comb begin
        new_blk = '0;
        for (int s = 0; s < SW_PER_STAGE; s++)
            if (lost[s]) new_blk[shuf[2*s+1].src] = 1'b1;
        for (int j = 0; j < PORTS; j++) begin
            shuf_v[j] = shuf[j].vld;
            swo_v[j]  = swo[j].vld;
        end
    end

    // R6
    conserve_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(swo_v) + $countones(new_blk)) == $countones(shuf_v));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < PORTS; j++) out_f[j] <= '0;
            out_blk <= '0;
        end else begin
            for (int j = 0; j < PORTS; j++) out_f[j] <= swo[j];
            out_blk <= in_blk | new_blk;
        end
    end
endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PORTS-1:0]              in_valid,
    input  logic [PORTS-1:0][ADDR_W-1:0]  in_dst,
    input  logic [PORTS-1:0][DATA_W-1:0]  in_data,
    output logic [PORTS-1:0]              out_valid,
    output logic [PORTS-1:0][ADDR_W-1:0]  out_src,
    output logic [PORTS-1:0][DATA_W-1:0]  out_data,
    output logic [PORTS-1:0]              blocked
);
    flit_t            pipe [STAGES+1][PORTS];
    logic [PORTS-1:0] bpipe [STAGES+1];

    for (genvar j = 0; j < PORTS; j++) begin : g_inj
        assign pipe[0][j] = '{vld: in_valid[j], src: ADDR_W'(j),
                              dst: in_dst[j], data: in_data[j]};
    end
    assign bpipe[0] = '0;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        omega_stage #(.STAGE(k)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .in_f   (pipe[k]),
            .in_blk (bpipe[k]),
            .out_f  (pipe[k+1]),
            .out_blk(bpipe[k+1])
        );
    end

    for (genvar j = 0; j < PORTS; j++) begin : g_out
        assign out_valid[j] = pipe[STAGES][j].vld;
        assign out_src[j]   = pipe[STAGES][j].src;
        assign out_data[j]  = pipe[STAGES][j].data;

        // R2
        lands_on_dst_chk: assert property (@(posedge clk) disable iff (rst)
            pipe[STAGES][j].vld |-> (pipe[STAGES][j].dst == ADDR_W'(j)));
        // R3
        not_both_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid[j] |-> !blocked[out_src[j]]);
    end
    assign blocked = bpipe[STAGES];

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_valid == '0 && blocked == '0));
endmodule

// File: tb/tb_omega_net.sv
`timescale 1ns/1ps
module tb_omega_net;
    import omega_pkg::*;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic [PORTS-1:0]             in_valid = '0;
    logic [PORTS-1:0][ADDR_W-1:0] in_dst = '0;
    logic [PORTS-1:0][DATA_W-1:0] in_data = '0;
    logic [PORTS-1:0]             out_valid, blocked;
    logic [PORTS-1:0][ADDR_W-1:0] out_src;
    logic [PORTS-1:0][DATA_W-1:0] out_data;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    omega_net dut (.*);

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            summary();
        end
    end

    function automatic logic [15:0] lfsr_next(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    // destination-tag model: position reached after each shuffle + switch
    task automatic model(input logic [PORTS-1:0] v, input logic [PORTS-1:0][ADDR_W-1:0] d,
                         output logic [PORTS-1:0] ev, output logic [PORTS-1:0][ADDR_W-1:0] es,
                         output logic [PORTS-1:0] eb);
        int pos [PORTS];
        int want [PORTS];
        bit alive [PORTS];
        ev = '0; es = '0; eb = '0;
        for (int s = 0; s < PORTS; s++) begin pos[s] = s; alive[s] = v[s]; end
        for (int i = 0; i < STAGES; i++) begin
            bit taken [PORTS];
            for (int p = 0; p < PORTS; p++) taken[p] = 0;
            for (int s = 0; s < PORTS; s++) begin
                pos[s]  = ((pos[s] << 1) | (pos[s] >> (ADDR_W-1))) % PORTS;
                want[s] = (pos[s] & ~1) | int'(d[s][ADDR_W-1-i]);
            end
            for (int s = 0; s < PORTS; s++)
                if (alive[s] && pos[s] % 2 == 0) taken[want[s]] = 1;
            for (int s = 0; s < PORTS; s++)
                if (alive[s] && pos[s] % 2 == 1) begin
                    if (taken[want[s]]) begin alive[s] = 0; eb[s] = 1'b1; end
                    else taken[want[s]] = 1;
                end
            for (int s = 0; s < PORTS; s++) pos[s] = want[s];
        end
        for (int s = 0; s < PORTS; s++)
            if (alive[s]) begin ev[pos[s]] = 1'b1; es[pos[s]] = ADDR_W'(s); end
    endtask

    task automatic compare(input string req, input logic [PORTS-1:0] ev,
                           input logic [PORTS-1:0][ADDR_W-1:0] es,
                           input logic [PORTS-1:0][DATA_W-1:0] sd,
                           input logic [PORTS-1:0] eb);
        for (int k = 0; k < PORTS; k++) begin
            n_vec++;
            if (out_valid[k] !== ev[k]) begin
                n_bad++;
                $display("FAIL %s out_valid[%0d] act=%b exp=%b", req, k, out_valid[k], ev[k]);
            end else if (ev[k] && (out_src[k] !== es[k] || out_data[k] !== sd[es[k]])) begin
                n_bad++;
                $display("FAIL %s port %0d src/data act=%0d/%h exp=%0d/%h", req, k,
                         out_src[k], out_data[k], es[k], sd[es[k]]);
            end
        end
        n_vec++;
        if (blocked !== eb) begin
            n_bad++;
            $display("FAIL %s blocked act=%b exp=%b", req, blocked, eb);
        end
    endtask

    task automatic load(input logic [PORTS-1:0] v, input logic [PORTS-1:0][ADDR_W-1:0] d,
                        input logic [7:0] tag, output logic [PORTS-1:0][DATA_W-1:0] sd);
        for (int j = 0; j < PORTS; j++) sd[j] = {tag, 8'(j * 17)};
        in_valid = v; in_dst = d; in_data = sd;
    endtask

    // one injection set, sampled STAGES edges later
    task automatic run_set(input string req, input logic [PORTS-1:0] v,
                           input logic [PORTS-1:0][ADDR_W-1:0] d, input logic [7:0] tag);
        logic [PORTS-1:0] ev, eb;
        logic [PORTS-1:0][ADDR_W-1:0] es;
        logic [PORTS-1:0][DATA_W-1:0] sd;
        model(v, d, ev, es, eb);
        @(negedge clk); load(v, d, tag, sd);
        @(negedge clk); in_valid = '0;
        @(negedge clk);
        @(negedge clk); compare(req, ev, es, sd, eb);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (out_valid !== '0 || blocked !== '0) begin
            n_bad++;
            $display("FAIL R1 after reset act=%b/%b exp=0/0", out_valid, blocked);
        end
    endtask

    task automatic t_perms();
        logic [PORTS-1:0][ADDR_W-1:0] d;
        for (int j = 0; j < PORTS; j++) d[j] = ADDR_W'(j);
        run_set("R2 R3 R4 identity", '1, d, 8'h11);
        for (int sh = 1; sh < PORTS; sh += 3) begin
            for (int j = 0; j < PORTS; j++) d[j] = ADDR_W'(j + sh);
            run_set("R4 shift", '1, d, 8'(8'h20 + sh));
        end
        for (int j = 0; j < PORTS; j++) d[j] = ~ADDR_W'(j);
        run_set("R4 complement", '1, d, 8'h33);
    endtask

    task automatic t_clash_pair();
        logic [PORTS-1:0][ADDR_W-1:0] d = '0;
        d[2] = 3'd7; d[6] = 3'd4;
        run_set("R5 pair", 8'b0100_0100, d, 8'h44);
        n_vec++;   // explicit R5 expectation, independent of the model
        if (!(blocked[6] && !blocked[2])) begin
            n_bad++;
            $display("FAIL R5 pair blocked act=%b exp=01000000", blocked);
        end
    endtask

    task automatic t_hotspot();
        logic [PORTS-1:0][ADDR_W-1:0] d;
        for (int j = 0; j < PORTS; j++) d[j] = 3'd5;
        run_set("R5 R6 all-to-one", '1, d, 8'h55);
        n_vec++;
        if ($countones(out_valid) != 1 || $countones(blocked) != PORTS-1) begin
            n_bad++;
            $display("FAIL R6 hotspot counts act=%0d/%0d exp=1/%0d",
                     $countones(out_valid), $countones(blocked), PORTS-1);
        end
    endtask

    task automatic t_sparse();
        logic [PORTS-1:0][ADDR_W-1:0] d;
        for (int j = 0; j < PORTS; j++) d[j] = 3'd1;
        run_set("R7 idle inputs", 8'b0000_0000, d, 8'h66);
        run_set("R7 one input", 8'b0001_0000, d, 8'h67);
    endtask

    task automatic t_random();
        for (int n = 0; n < 60; n++) begin
            logic [PORTS-1:0] v;
            logic [PORTS-1:0][ADDR_W-1:0] d;
            lfsr = lfsr_next(lfsr); v = lfsr[PORTS-1:0];
            for (int j = 0; j < PORTS; j++) begin
                lfsr = lfsr_next(lfsr); d[j] = lfsr[ADDR_W-1:0];
            end
            run_set("R6 random", v, d, 8'(n));
        end
    endtask

    task automatic t_back_to_back();
        logic [PORTS-1:0] va, vb, eva, evb, eba, ebb;
        logic [PORTS-1:0][ADDR_W-1:0] da, db, esa, esb;
        logic [PORTS-1:0][DATA_W-1:0] sda, sdb;
        va = '1; vb = 8'b1100_1100;
        for (int j = 0; j < PORTS; j++) begin da[j] = ADDR_W'(j + 2); db[j] = 3'd3; end
        model(va, da, eva, esa, eba);
        model(vb, db, evb, esb, ebb);
        @(negedge clk); load(va, da, 8'hA1, sda);
        @(negedge clk); load(vb, db, 8'hB2, sdb);
        @(negedge clk); in_valid = '0;
        @(negedge clk); compare("R8 first set", eva, esa, sda, eba);
        @(negedge clk); compare("R8 second set", evb, esb, sdb, ebb);
    endtask

    initial begin
        t_reset();
        t_perms();
        t_clash_pair();
        t_hotspot();
        t_sparse();
        t_random();
        t_back_to_back();
        done = 1;
        summary();
    end
endmodule